// File: doc/BRIEF.md
# Four-function 4-bit register

This block is a small register that runs one of four operations on its own contents at every rising clock edge. A 2-bit mode input picks the operation: add three, shift toward the most significant bit, bitwise inversion, or shift toward the least significant bit. Each shift direction has its own serial input, which supplies the bit that enters at the vacated end. The stored value is always visible on a parallel output.

There is no hold, load or carry output. A new value comes from a synchronous reset followed by a sequence of shifts, and every edge outside reset changes the state according to the mode. The width and the added constant are parameters. Their defaults are four bits and three.

Top module: `mfr_quad_reg`

## Requirements
- R1: While `rst` is high at a rising edge, `q` becomes 0 after that edge whatever `mode` and the serial inputs hold. The reset takes priority over every mode.
- R2: With `mode` = 2'b00, `q` becomes (`q` + 3) modulo 16 at the edge. The carry out of bit 3 is lost, so 14 becomes 1 and 15 becomes 2.
- R3: With `mode` = 2'b01, `q[3:1]` takes the old `q[2:0]` and `q[0]` takes `ser_lsb_in`.
- R4: With `mode` = 2'b10, every bit of `q` is inverted.
- R5: With `mode` = 2'b11, `q[2:0]` takes the old `q[3:1]` and `q[3]` takes `ser_msb_in`.
- R6: An operation is applied at every non-reset edge and no mode holds the value. Back-to-back edges with different modes each take effect in turn.
- R7: `ser_msb_in` has no effect in modes 00, 01 and 10. `ser_lsb_in` has no effect in modes 00, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Operation select: 00 add three, 01 shift left, 10 invert, 11 shift right |
| ser_lsb_in | input | 1 | Bit entering bit 0 on a left shift |
| ser_msb_in | input | 1 | Bit entering bit 3 on a right shift |
| q | output | 4 | Register contents |

## Verification
The adder is run from zero through a full cycle of add-three steps. This walks through 15 to 2 and 14 to 1, so a kept carry or a wrong constant shows up. Each shift is driven with its own serial input set opposite to the other one's, starting from asymmetric values. This separates a swapped direction, a swapped serial input and a lost end bit. Inversion is applied twice with both serial inputs high, which shows both the change on every edge and that those inputs are ignored. A mixed sequence with a new mode on each edge, and a reset asserted alongside a non-zero mode, confirm that every edge is used and that reset wins.

// File: rtl/mfr_pkg.sv
package mfr_pkg;

    parameter int unsigned REG_W     = 4;
    parameter int unsigned ADD_CONST = 3;

    typedef enum logic [1:0] {
        OP_ADD3 = 2'b00,
        OP_SHL  = 2'b01,
        OP_INV  = 2'b10,
        OP_SHR  = 2'b11
    } op_e;

endpackage

// File: rtl/mfr_add_const.sv
module mfr_add_const #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned ADDEND = 3
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam logic [WIDTH-1:0] ADDEND_W = WIDTH'(ADDEND);

    // Sum truncated to WIDTH bits: carry out of the top bit is dropped.
    always_comb begin
        dout = din + ADDEND_W;
    end
endmodule

// File: rtl/mfr_shifter.sv
module mfr_shifter #(
    parameter int unsigned WIDTH = 4,
    parameter bit          LEFT  = 1'b1
) (
    input  logic [WIDTH-1:0] din,
    input  logic             fill,
    output logic [WIDTH-1:0] dout
);
    generate
        if (LEFT) begin : g_left
            always_comb dout = {din[WIDTH-2:0], fill};
        end else begin : g_right
            always_comb dout = {fill, din[WIDTH-1:1]};
        end
    endgenerate
endmodule

// File: rtl/mfr_quad_reg.sv
module mfr_quad_reg
    import mfr_pkg::*;
#(
    parameter int unsigned WIDTH  = REG_W,
    parameter int unsigned ADDEND = ADD_CONST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             ser_lsb_in,
    input  logic             ser_msb_in,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ADDEND_W = WIDTH'(ADDEND);

    typedef struct packed {
        logic [WIDTH-1:0] val;
    } state_t;

    state_t           st_d, st_q;
    logic [WIDTH-1:0] sum_w, shl_w, shr_w;

    mfr_add_const #(.WIDTH(WIDTH), .ADDEND(ADDEND)) u_add (
        .din (st_q.val),
        .dout(sum_w)
    );

    mfr_shifter #(.WIDTH(WIDTH), .LEFT(1'b1)) u_shl (
        .din (st_q.val),
        .fill(ser_lsb_in),
        .dout(shl_w)
    );

    mfr_shifter #(.WIDTH(WIDTH), .LEFT(1'b0)) u_shr (
        .din (st_q.val),
        .fill(ser_msb_in),
        .dout(shr_w)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.val = '0;
        end else begin
            unique case (op_e'(mode))
                OP_ADD3: st_d.val = sum_w;
                OP_SHL:  st_d.val = shl_w;
                OP_INV:  st_d.val = ~st_q.val;
                OP_SHR:  st_d.val = shr_w;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.val;

    // Reset wins over any mode
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

    assert_add_wraps_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> (q == WIDTH'($past(q) + ADDEND_W)));

    // Also covers R7: the msb serial input plays no part
    assert_shift_left_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |=> (q == {$past(q[WIDTH-2:0]), $past(ser_lsb_in)}));

    assert_invert_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |=> (q == ~$past(q)));

    // Also covers R7: the lsb serial input plays no part
    assert_shift_right_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11) |=> (q == {$past(ser_msb_in), $past(q[WIDTH-1:1])}));

    // Adding a non-zero constant or inverting never leaves the value unchanged
    assert_no_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 || mode == 2'b10) |=> !$stable(q));
endmodule

// File: tb/sim_mfr_quad_reg.sv
module sim_mfr_quad_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       ser_lsb_in = 1'b0;
    logic       ser_msb_in = 1'b0;
    logic [3:0] q;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    mfr_quad_reg u0 (
        .clk(clk), .rst(rst), .mode(mode),
        .ser_lsb_in(ser_lsb_in), .ser_msb_in(ser_msb_in), .q(q)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%b expected %b", tag, act, exp);
        end
    endtask

    // Drive inputs at the falling edge, let one rising edge pass, sample after it
    task automatic step(input logic r, input logic [1:0] m, input logic sl, input logic sr);
        @(negedge clk);
        rst = r; mode = m; ser_lsb_in = sl; ser_msb_in = sr;
        @(posedge clk);
        #1;
    endtask

    task automatic load_val(input logic [3:0] v);
        step(1'b1, 2'b10, 1'b1, 1'b1);
        for (int i = 3; i >= 0; i--) step(1'b0, 2'b01, v[i], 1'b0);
    endtask

    task automatic t_reset;
        step(1'b1, 2'b00, 1'b0, 1'b0);
        check("R1 reset state", q, 4'd0);
        load_val(4'b1010);
        check("R3 load via shifts", q, 4'b1010);
        step(1'b1, 2'b10, 1'b1, 1'b1);
        check("R1 reset over invert", q, 4'd0);
        load_val(4'b0111);
        step(1'b1, 2'b00, 1'b0, 1'b0);
        check("R1 reset over add", q, 4'd0);
    endtask

    task automatic t_add3;
        logic [3:0] exp = 4'd0;
        step(1'b1, 2'b00, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            step(1'b0, 2'b00, i[0], i[1]);
            exp = exp + 4'd3;
            check("R2 add three modulo 16 (R7 serial ignored)", q, exp);
        end
        load_val(4'd14);
        step(1'b0, 2'b00, 1'b1, 1'b1);
        check("R2 14 wraps to 1", q, 4'd1);
    endtask

    task automatic t_shl;
        load_val(4'b0110);
        step(1'b0, 2'b01, 1'b1, 1'b0);
        check("R3 shift left fill 1", q, 4'b1101);
        step(1'b0, 2'b01, 1'b0, 1'b1);
        check("R3 shift left fill 0, R7 msb input ignored", q, 4'b1010);
    endtask

    task automatic t_inv;
        load_val(4'b1010);
        step(1'b0, 2'b10, 1'b1, 1'b1);
        check("R4 invert", q, 4'b0101);
        step(1'b0, 2'b10, 1'b1, 1'b1);
        check("R4 invert back, R7 serial ignored", q, 4'b1010);
    endtask

    task automatic t_shr;
        load_val(4'b1001);
        step(1'b0, 2'b11, 1'b0, 1'b1);
        check("R5 shift right fill 1", q, 4'b1100);
        step(1'b0, 2'b11, 1'b1, 1'b0);
        check("R5 shift right fill 0, R7 lsb input ignored", q, 4'b0110);
    endtask

    task automatic t_mixed;
        step(1'b1, 2'b00, 1'b0, 1'b0);
        step(1'b0, 2'b00, 1'b0, 1'b0);
        check("R6 mixed add", q, 4'b0011);
        step(1'b0, 2'b01, 1'b1, 1'b0);
        check("R6 mixed shift left", q, 4'b0111);
        step(1'b0, 2'b10, 1'b0, 1'b0);
        check("R6 mixed invert", q, 4'b1000);
        step(1'b0, 2'b11, 1'b0, 1'b0);
        check("R6 mixed shift right", q, 4'b0100);
        step(1'b0, 2'b00, 1'b0, 1'b0);
        check("R6 mixed add again", q, 4'b0111);
    endtask

    initial begin
        t_reset();
        t_add3();
        t_shl();
        t_inv();
        t_shr();
        t_mixed();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule